// File: doc/BRIEF.md
# Two-Stage Key Lock for a Flash Control Register

This block stands between a simple register write bus and the control register of a flash controller. Two lock bits protect it. The main lock gates every write to the control register. A second, option lock sits behind the main lock and gates writes to the option registers. Each lock opens only when software writes an exact pair of 32-bit magic words, in the right order, to the key address that belongs to that lock. The option lock cannot be opened unless the main lock is already open.

Software closes either lock again by writing 1 to its bit in the control register. If a key arrives that is wrong, out of order, or written while its lock is already open, the block raises a one-cycle bus error. The lock it was aimed at then stays shut until the next reset. The block drives two permission outputs, one for the control register and one for the option registers, and presents the control register value on its read port.

Top module: `key_lock_ctrl`

## Requirements
- R1: After reset, ctrl_o reads 0xC000_0000: bit 31 (main lock) and bit 30 (option lock) are 1 and bits 29:0 are 0. ctrl_wr_en_o, opt_wr_en_o and bus_err_o are 0.
- R2: Write 0x4567_0123 and then 0xCDEF_89AB to the main key address (0x2). The main lock clears on the clock edge that takes the second word, so bit 31 reads 0 and ctrl_wr_en_o is 1.
- R3: With the main lock open, write 0x0819_2A3B and then 0x4C5D_6E7F to the option key address (0x3). The option lock clears, so bit 30 reads 0 and opt_wr_en_o is 1.
- R4: A write to the option key address while the main lock is set raises bus_err_o. The option lock then stays set until reset, even after the main lock opens and the correct option keys are written.
- R5: A wrong main key, or the second main key written first, raises bus_err_o. The main lock then stays set until reset, and a later correct sequence does not open it.
- R6: A key write to a lock that is already open counts as a wrong key. It raises bus_err_o, sets that lock, and keeps it set until reset.
- R7: While the main lock is set, writes to the control address (0x5) leave bits 29:0 unchanged, including writes that set bit 31.
- R8: With the main lock open, writing 1 to bit 31 sets both locks on that edge. A fresh correct main sequence opens the main lock again.
- R9: With the main lock open, a control write stores bits 29:0. Writing 1 to bit 30 sets only the option lock.
- R10: opt_wr_en_o is never 1 while ctrl_wr_en_o is 0.
- R11: Writes to other addresses between the two key words do not break the sequence. This includes unmapped addresses and ignored control writes.
- R12: bus_err_o is 1 for exactly the cycle after each bad key write. It is 0 at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe, one write per cycle |
| addr_i | input | ADDR_W | Write address |
| wdata_i | input | DATA_W | Write data |
| ctrl_o | output | DATA_W | Control register value: bit 31 main lock, bit 30 option lock, bits 29:0 stored data |
| ctrl_wr_en_o | output | 1 | Control register writes are permitted |
| opt_wr_en_o | output | 1 | Option register writes are permitted |
| bus_err_o | output | 1 | One-cycle pulse after a rejected key write |

## Verification
The bench builds the block with its default parameters. These are a 32-bit data path, a 4-bit address, key addresses 0x2 and 0x3, and the control register at 0x5. Because the address is 4 bits wide, unmapped addresses such as 0x7 are available, so the test can slip stray writes between key words. The default magic words let the bench reach the cases where the two key pairs are confused, where they arrive out of order, and where they are replayed. A behavioural model advances on every write, and the bench compares every output with it on every clock.

// File: rtl/klc_pkg.sv
package klc_pkg;
  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_HALF = 2'd1,
    KS_OPEN = 2'd2,
    KS_DEAD = 2'd3
  } key_st_e;
endpackage

// File: rtl/klc_key_seq.sv
module klc_key_seq import klc_pkg::*; #(
  parameter int          W  = 32,
  parameter logic [W-1:0] K1 = '0,
  parameter logic [W-1:0] K2 = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         key_wr_i,
  input  logic [W-1:0] key_i,
  input  logic         enable_i,
  input  logic         relock_i,
  output logic         open_o,
  output logic         open_nxt_o,
  output logic         bad_o
);
  key_st_e st_q, st_d;

  always_comb begin
    st_d  = st_q;
    bad_o = 1'b0;
    if (key_wr_i) begin
      if (!enable_i) begin
        st_d  = KS_DEAD;
        bad_o = 1'b1;
      end else begin
        unique case (st_q)
          KS_IDLE: if (key_i == K1) st_d = KS_HALF; else begin st_d = KS_DEAD; bad_o = 1'b1; end
          KS_HALF: if (key_i == K2) st_d = KS_OPEN; else begin st_d = KS_DEAD; bad_o = 1'b1; end
          default: begin st_d = KS_DEAD; bad_o = 1'b1; end
        endcase
      end
    end else if (relock_i && st_q != KS_DEAD) begin
      st_d = KS_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= KS_IDLE;
    else         st_q <= st_d;

  assign open_o     = (st_q == KS_OPEN);
  assign open_nxt_o = (st_d == KS_OPEN);

  // dead state is left only through reset
  assert_dead_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == KS_DEAD |=> st_q == KS_DEAD);
  // opening needs the second key right after the first
  assert_open_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != KS_OPEN) ##1 (st_q == KS_OPEN) |->
      $past(st_q) == KS_HALF && $past(key_wr_i) && $past(key_i) == K2);
endmodule

// File: rtl/klc_ctrl_data.sv
module klc_ctrl_data #(
  parameter int W = 30
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         allow_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              data_q <= '0;
    else if (wr_i && allow_i) data_q <= d_i;

  assign q_o = data_q;

  assert_locked_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !allow_i) |=> $stable(data_q));
endmodule

// File: rtl/key_lock_ctrl.sv
module key_lock_ctrl #(
  parameter int                DATA_W    = 32,
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] ADDR_MKEY = 4'h2,
  parameter logic [ADDR_W-1:0] ADDR_OKEY = 4'h3,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 4'h5,
  parameter logic [DATA_W-1:0] MKEY1     = 32'h4567_0123,
  parameter logic [DATA_W-1:0] MKEY2     = 32'hCDEF_89AB,
  parameter logic [DATA_W-1:0] OKEY1     = 32'h0819_2A3B,
  parameter logic [DATA_W-1:0] OKEY2     = 32'h4C5D_6E7F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              ctrl_wr_en_o,
  output logic              opt_wr_en_o,
  output logic              bus_err_o
);
  localparam int MLOCK = DATA_W - 1;
  localparam int OLOCK = DATA_W - 2;
  localparam int CW    = DATA_W - 2;

  logic mkey_wr, okey_wr, ctrl_wr;
  logic m_open, m_open_nxt, m_bad, m_relock;
  logic o_open, o_open_nxt, o_bad, o_relock;
  logic err_q;
  logic [CW-1:0] data_q;

  assign mkey_wr = we_i && (addr_i == ADDR_MKEY);
  assign okey_wr = we_i && (addr_i == ADDR_OKEY);
  assign ctrl_wr = we_i && (addr_i == ADDR_CTRL);

  assign m_relock = ctrl_wr && m_open && wdata_i[MLOCK];
  // option lock follows the main lock down on the same edge
  assign o_relock = (ctrl_wr && m_open && (wdata_i[MLOCK] || wdata_i[OLOCK])) || !m_open_nxt;

  klc_key_seq #(.W(DATA_W), .K1(MKEY1), .K2(MKEY2)) u_main (
    .clk_i, .rst_ni, .key_wr_i(mkey_wr), .key_i(wdata_i), .enable_i(1'b1),
    .relock_i(m_relock), .open_o(m_open), .open_nxt_o(m_open_nxt), .bad_o(m_bad));

  klc_key_seq #(.W(DATA_W), .K1(OKEY1), .K2(OKEY2)) u_opt (
    .clk_i, .rst_ni, .key_wr_i(okey_wr), .key_i(wdata_i), .enable_i(m_open),
    .relock_i(o_relock), .open_o(o_open), .open_nxt_o(o_open_nxt), .bad_o(o_bad));

  klc_ctrl_data #(.W(CW)) u_data (
    .clk_i, .rst_ni, .wr_i(ctrl_wr), .allow_i(m_open), .d_i(wdata_i[CW-1:0]), .q_o(data_q));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= m_bad || o_bad;

  assign ctrl_o       = {!m_open, !o_open, data_q};
  assign ctrl_wr_en_o = m_open;
  assign opt_wr_en_o  = m_open && o_open;
  assign bus_err_o    = err_q;

  assert_opt_needs_main_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opt_wr_en_o |-> ctrl_wr_en_o);
  assert_err_cause_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> $past(we_i) && ($past(addr_i) == ADDR_MKEY || $past(addr_i) == ADDR_OKEY));
  assert_relock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wdata_i[MLOCK]) |=> !ctrl_wr_en_o && !opt_wr_en_o);
  assert_opt_open_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(o_open) |-> $past(okey_wr) && $past(m_open));
endmodule

// File: tb/sim_key_lock_ctrl.sv
module sim_key_lock_ctrl;
  localparam logic [3:0] AM = 4'h2, AO = 4'h3, AC = 4'h5, AX = 4'h7;
  localparam logic [31:0] MK1 = 32'h4567_0123, MK2 = 32'hCDEF_89AB;
  localparam logic [31:0] OK1 = 32'h0819_2A3B, OK2 = 32'h4C5D_6E7F;

  logic clk = 0, rst_ni = 0, we = 0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, ctrl;
  logic cen, oen, berr;
  always #4 clk = ~clk;

  key_lock_ctrl u0 (.clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ctrl_o(ctrl), .ctrl_wr_en_o(cen), .opt_wr_en_o(oen), .bus_err_o(berr));

  int n_chk = 0, n_err = 0;
  int m_st = 0, o_st = 0;   // 0 idle, 1 half, 2 open, 3 dead
  logic [29:0] dat = '0;
  logic exp_err = 0;
  bit run = 0, done = 0;
  string tag = "R1";

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_ni && run) begin
      chk(tag, ctrl, {m_st != 2, o_st != 2, dat}, "ctrl_o");
      chk(tag, {31'd0, cen}, {31'd0, m_st == 2}, "ctrl_wr_en_o");
      chk(tag, {31'd0, oen}, {31'd0, m_st == 2 && o_st == 2}, "opt_wr_en_o");
      chk("R12", {31'd0, berr}, {31'd0, exp_err}, "bus_err_o");
      if (oen && !cen) chk("R10", 1, 0, "opt without main");
    end
  end

  function automatic int step(input int st, input logic [31:0] d, input logic [31:0] k1,
                              input logic [31:0] k2, inout logic bad);
    if (st == 0 && d == k1) return 1;
    if (st == 1 && d == k2) return 2;
    bad = 1;
    return 3;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic bad;
    @(negedge clk);
    we = 1; addr = a; wdata = d; bad = 0;
    if (a == AM) m_st = step(m_st, d, MK1, MK2, bad);
    else if (a == AO) begin
      if (m_st != 2) begin o_st = 3; bad = 1; end
      else o_st = step(o_st, d, OK1, OK2, bad);
    end else if (a == AC && m_st == 2) begin
      dat = d[29:0];
      if (d[31]) m_st = 0;
      if ((d[31] || d[30]) && o_st != 3) o_st = 0;
    end
    if (m_st != 2 && o_st != 3) o_st = 0;
    exp_err = bad;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      we = 0; exp_err = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    we = 0; rst_ni = 0; run = 0;
    m_st = 0; o_st = 0; dat = '0; exp_err = 0;
    idle(2);
    rst_ni = 1; run = 1;
    idle(1);
  endtask

  initial begin
    #(8 * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    tag = "R1";
    chk("R1", ctrl, 32'hC000_0000, "reset ctrl_o");
    chk("R1", {29'd0, cen, oen, berr}, 32'd0, "reset outputs");

    tag = "R7";
    wr(AC, 32'h0000_1234); wr(AC, 32'h8000_0055); idle(2);
    chk("R7", ctrl, 32'hC000_0000, "locked write ignored");

    tag = "R11";
    wr(AM, MK1); wr(AX, 32'hFFFF_FFFF); wr(AC, 32'h0000_0777); idle(1);
    tag = "R2";
    wr(AM, MK2); idle(2);
    chk("R2", {31'd0, cen}, 32'd1, "main open");

    tag = "R9";
    wr(AC, 32'h0000_0155); idle(1);
    chk("R9", ctrl[29:0], 30'h155, "data stored");
    tag = "R3";
    wr(AO, OK1); wr(AO, OK2); idle(2);
    chk("R3", {31'd0, oen}, 32'd1, "option open");
    tag = "R9";
    wr(AC, 32'h4000_0AAA); idle(2);
    chk("R9", ctrl, 32'h4000_0AAA, "option relocked, main open");

    tag = "R8";
    wr(AO, OK1); wr(AO, OK2); wr(AC, 32'h8000_0003); idle(2);
    chk("R8", {30'd0, cen, oen}, 32'd0, "both relocked");
    wr(AM, MK1); wr(AM, MK2); idle(1);
    chk("R8", {31'd0, cen}, 32'd1, "main reopens");

    tag = "R6";
    wr(AM, MK1); idle(2);
    chk("R6", {31'd0, cen}, 32'd0, "replay relocks");
    wr(AM, MK1); wr(AM, MK2); idle(2);
    chk("R6", {31'd0, cen}, 32'd0, "stuck after replay");

    do_reset();
    tag = "R5";
    wr(AM, MK2); wr(AM, MK1); wr(AM, MK2); idle(2);
    chk("R5", {31'd0, cen}, 32'd0, "out of order stays locked");
    do_reset();
    tag = "R5";
    wr(AM, MK1); wr(AM, OK2); idle(1);
    wr(AM, MK1); wr(AM, MK2); idle(2);
    chk("R5", {31'd0, cen}, 32'd0, "wrong key stays locked");

    do_reset();
    tag = "R4";
    wr(AO, OK1); idle(1);
    wr(AM, MK1); wr(AM, MK2); wr(AO, OK1); wr(AO, OK2); idle(2);
    chk("R4", {30'd0, cen, oen}, 32'd2, "option dead");

    do_reset();
    tag = "R6";
    wr(AM, MK1); wr(AM, MK2); wr(AO, OK1); wr(AO, OK2); wr(AO, OK1); idle(2);
    chk("R6", {30'd0, cen, oen}, 32'd2, "option replay");

    tag = "R12";
    wr(AO, OK2); wr(AM, 32'd0); idle(3);
    chk("R12", {31'd0, berr}, 32'd0, "error quiet");

    idle(2);
    finish_run();
  end
endmodule